// File: doc/BRIEF.md
# Power-Management Event and Timer Unit

This block holds the event status and event enable registers of a power-management controller, together with a free-running power-management timer. Software reaches all three through a small register bus. The status register is at offset 0, the enable register is at offset 2 and the timer is at offset 8. Reads are combinational from the address.

The timer advances on an externally supplied tick strobe. The block keeps an overflow point, which is the next multiple of a power-of-two step above the count. When the count reaches that point, the timer status bit is raised. Wake reasons and power-button events from the system also set status bits. Each source whose status and enable bits are both set shows up on a per-source pending vector. The OR of that vector is an interrupt request for the interrupt combiner. The block also drives the wake-enable lines for the real-time-clock and timer wake sources.

The parameter `OVF_LOG2` sets the log2 of the overflow step. By default it is 23, which gives a step of 0x800000. The parameter `TMR_W` sets the visible timer width and defaults to 24. The parameter `CNT_W` sets the internal count width and defaults to 32.

Top module: `pm_event_unit`

## Requirements
- R1: Synchronous active-low reset clears the status register, the enable register and the internal count to zero. It also leaves the overflow point disarmed.
- R2: While `tmr_tick` is 1, the count goes up by one per clock. A read at offset 8 returns the low `TMR_W` bits of the count, zero-extended. Writes at offset 8 change nothing.
- R3: A write at offset 0 clears each status bit written as 1 and leaves each bit written as 0 unchanged. The status bit positions are: timer bit 0, power button bit 8, RTC bit 10, wake bit 15.
- R4: A status write with bit 0 set arms the overflow point if the timer status bit is 1 or the point is disarmed. The new point is the count plus 2^OVF_LOG2, rounded down to a multiple of 2^OVF_LOG2. Once the count is at or above an armed point, timer status is set one clock later. While the point is disarmed, timer status is never set by the count.
- R5: When `wake_req` is 1, `wake_why` selects which bits are set. Code 0 is the RTC and sets wake status plus RTC status. Code 1 is the timer and sets wake status plus timer status. Codes 2 and 3 are any other reason and set wake status plus power-button status.
- R6: A `pwrbtn_evt` pulse sets power-button status only when enable bit 8 is 1. When enable bit 8 is 0, the pulse leaves status unchanged.
- R7: A write at offset 2 loads the enable register, and the register reads back at offset 2. `rtc_wake_en` follows enable bit 10 and `tmr_wake_en` follows enable bit 0.
- R8: `tmr_wake_arm` is 1 only while enable bit 0 is 1 and timer status is 0.
- R9: `src_pend` is {RTC, power button, timer}. Each bit is the AND of that source's status and enable bits. `pm_irq` is the OR of `src_pend`.
- R10: If an event sets a status bit in the same clock as a write that clears it, the bit ends up set.
- R11: Reads at any offset other than 0, 2 and 8 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_tick | input | 1 | Timer increment strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| wake_req | input | 1 | Wake event pulse |
| wake_why | input | 2 | Wake reason code |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| rtc_wake_en | output | 1 | RTC wake source enable |
| tmr_wake_en | output | 1 | Timer wake source enable |
| tmr_wake_arm | output | 1 | Timer wake source armed |
| src_pend | output | 3 | Per-source pending {RTC, button, timer} |
| pm_irq | output | 1 | OR of pending sources |

## Verification
The bench places the count exactly one short of an overflow point and checks that timer status is still clear. It then checks that status sets after the final tick. A design that rounded the point wrongly, or compared with strict greater-than, would set timer status one step early or late. The bench also clears a set timer status mid-window and expects the next point to be computed from the current count. It leaves a fresh reset unarmed through many ticks, where a design that armed at zero would raise timer status straight away. Finally, it collides events with clearing writes and fires a disabled power button, which catches a design that lets the clear win or ignores the enable gate.

// File: rtl/pm_evt_pkg.sv
`timescale 1ns/1ps
// Shared constants for the power-management event unit: status/enable
// bit positions, register offsets and wake reason codes.
package pm_evt_pkg;
    localparam int TMR_BIT    = 0;
    localparam int PWRBTN_BIT = 8;
    localparam int RTC_BIT    = 10;
    localparam int WAKE_BIT   = 15;

    localparam logic [3:0] OFS_STS = 4'd0;
    localparam logic [3:0] OFS_EN  = 4'd2;
    localparam logic [3:0] OFS_TMR = 4'd8;

    typedef enum logic [1:0] {
        WHY_RTC   = 2'd0,
        WHY_TMR   = 2'd1,
        WHY_OTHER = 2'd2
    } wake_why_e;
endpackage

// File: rtl/pm_tmr_core.sv
`timescale 1ns/1ps
// Free-running power-management counter with an overflow point.
// Assumes: tick is a single-cycle strobe; rearm is only asserted by the
// status-write logic. The point is aligned to 2^OVF_LOG2; CNT_W must be
// wider than OVF_LOG2 so the point does not wrap in normal operation.
module pm_tmr_core #(
    parameter int CNT_W    = 32,
    parameter int TMR_W    = 24,
    parameter int OVF_LOG2 = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rearm,
    output logic [TMR_W-1:0] cnt_o,
    output logic             hit_o,
    output logic             armed_o
);
    localparam logic [CNT_W-1:0] STEP  = {{(CNT_W-1){1'b0}}, 1'b1} << OVF_LOG2;
    localparam logic [CNT_W-1:0] ALIGN = ~(STEP - 1'b1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ovf_q;
    logic             armed_q;

    // Count advances once per tick strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // Overflow point: disarmed at reset, recomputed from the count on rearm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q   <= '0;
            armed_q <= 1'b0;
        end else if (rearm) begin
            ovf_q   <= (cnt_q + STEP) & ALIGN;
            armed_q <= 1'b1;
        end
    end

    // Hit is masked in the rearm cycle so the old point cannot re-set status.
    always_comb begin
        hit_o   = armed_q && !rearm && (cnt_q >= ovf_q);
        cnt_o   = cnt_q[TMR_W-1:0];
        armed_o = armed_q;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == $past(cnt_q) + 1'b1);
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R4
    rearm_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> armed_q && (ovf_q >= cnt_q) && (ovf_q[OVF_LOG2-1:0] == '0));
endmodule

// File: rtl/pm_sts_regs.sv
`timescale 1ns/1ps
// Event status (write-one-to-clear) and enable registers.
// Assumes: event inputs are single-cycle pulses; on a collision, a set
// from an event wins over a clear from a write in the same cycle.
module pm_sts_regs
    import pm_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sts_wr,
    input  logic        en_wr,
    input  logic [15:0] wdata,
    input  logic        wake_req,
    input  logic [1:0]  wake_why,
    input  logic        pwrbtn,
    input  logic        tmr_hit,
    output logic [15:0] sts_o,
    output logic [15:0] en_o
);
    logic [15:0] sts_q, en_q, set_v, clr_v;

    // Collect the bits set by events this cycle.
    always_comb begin
        set_v = '0;
        if (tmr_hit) set_v[TMR_BIT] = 1'b1;
        if (wake_req) begin
            set_v[WAKE_BIT] = 1'b1;
            case (wake_why)
                WHY_RTC: set_v[RTC_BIT]    = 1'b1;
                WHY_TMR: set_v[TMR_BIT]    = 1'b1;
                default: set_v[PWRBTN_BIT] = 1'b1;
            endcase
        end
        if (pwrbtn && en_q[PWRBTN_BIT]) set_v[PWRBTN_BIT] = 1'b1;
        clr_v = sts_wr ? wdata : 16'h0000;
    end

    // Status register update: clear written ones, then apply sets.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_v) | set_v;
    end

    // Enable register load.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata;
    end

    assign sts_o = sts_q;
    assign en_o  = en_q;

    // R3
    w1c_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr && wdata[WAKE_BIT] && !wake_req |=> !sts_q[WAKE_BIT]);
    // R6
    pwrbtn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwrbtn && !en_q[PWRBTN_BIT] && !wake_req && !sts_wr |=> $stable(sts_q));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> sts_q[WAKE_BIT]);
endmodule

// File: rtl/pm_pend_map.sv
`timescale 1ns/1ps
// Maps per-source status and enable bits to pending lines, the combined
// request and the wake-source enables. Purely combinational.
module pm_pend_map (
    input  logic [2:0] sts_src,   // {rtc, button, timer}
    input  logic [2:0] en_src,    // {rtc, button, timer}
    output logic [2:0] src_pend,
    output logic       irq,
    output logic       rtc_wake_en,
    output logic       tmr_wake_en,
    output logic       tmr_wake_arm
);
    // Pending and wake-enable outputs from current register state.
    always_comb begin
        src_pend     = sts_src & en_src;
        irq          = |src_pend;
        rtc_wake_en  = en_src[2];
        tmr_wake_en  = en_src[0];
        tmr_wake_arm = en_src[0] && !sts_src[0];
    end
endmodule

// File: rtl/pm_event_unit.sv
`timescale 1ns/1ps
// Power-management event and timer unit: register decode and read mux,
// timer core, status/enable registers and pending map.
// Assumes: one register write per cycle; reads are combinational.
module pm_event_unit
    import pm_evt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int TMR_W    = 24,
    parameter int OVF_LOG2 = 23,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_req,
    input  logic [1:0]        wake_why,
    input  logic              pwrbtn_evt,
    output logic              rtc_wake_en,
    output logic              tmr_wake_en,
    output logic              tmr_wake_arm,
    output logic [2:0]        src_pend,
    output logic              pm_irq
);
    logic              sts_wr, en_wr, rearm, tmr_hit, armed;
    logic [TMR_W-1:0]  cnt;
    logic [15:0]       sts, en;

    // Write decode and timer rearm condition.
    always_comb begin
        sts_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STS));
        en_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_EN));
        rearm  = sts_wr && bus_wdata[TMR_BIT] && (sts[TMR_BIT] || !armed);
    end

    pm_tmr_core #(.CNT_W(CNT_W), .TMR_W(TMR_W), .OVF_LOG2(OVF_LOG2)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .rearm(rearm),
        .cnt_o(cnt), .hit_o(tmr_hit), .armed_o(armed)
    );

    pm_sts_regs u_regs (
        .clk(clk), .rst_n(rst_n), .sts_wr(sts_wr), .en_wr(en_wr),
        .wdata(bus_wdata), .wake_req(wake_req), .wake_why(wake_why),
        .pwrbtn(pwrbtn_evt), .tmr_hit(tmr_hit), .sts_o(sts), .en_o(en)
    );

    pm_pend_map u_pend (
        .sts_src({sts[RTC_BIT], sts[PWRBTN_BIT], sts[TMR_BIT]}),
        .en_src ({en[RTC_BIT],  en[PWRBTN_BIT],  en[TMR_BIT]}),
        .src_pend(src_pend), .irq(pm_irq),
        .rtc_wake_en(rtc_wake_en), .tmr_wake_en(tmr_wake_en),
        .tmr_wake_arm(tmr_wake_arm)
    );

    // Read mux by offset; unmapped offsets read zero.
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_STS))      bus_rdata = DATA_W'(sts);
        else if (bus_addr == ADDR_W'(OFS_EN))  bus_rdata = DATA_W'(en);
        else if (bus_addr == ADDR_W'(OFS_TMR)) bus_rdata = DATA_W'(cnt);
        else                                   bus_rdata = '0;
    end

    // R7
    rtc_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> rtc_wake_en == $past(bus_wdata[RTC_BIT]));
    // R8
    arm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wake_arm |-> tmr_wake_en && !src_pend[0]);
endmodule

// File: tb/tb_pm_event_unit.sv
`timescale 1ns/1ps
module tb_pm_event_unit;
    localparam int TMR_W = 8;
    localparam int OVF_LOG2 = 5;
    localparam int CNT_W = 16;

    logic clk = 1'b0, rst_n = 1'b0, tmr_tick = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic wake_req = 1'b0, pwrbtn_evt = 1'b0;
    logic [1:0] wake_why = '0;
    logic rtc_wake_en, tmr_wake_en, tmr_wake_arm, pm_irq;
    logic [2:0] src_pend;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pm_event_unit #(.CNT_W(CNT_W), .TMR_W(TMR_W), .OVF_LOG2(OVF_LOG2)) dut (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_req(wake_req), .wake_why(wake_why), .pwrbtn_evt(pwrbtn_evt),
        .rtc_wake_en(rtc_wake_en), .tmr_wake_en(tmr_wake_en),
        .tmr_wake_arm(tmr_wake_arm), .src_pend(src_pend), .pm_irq(pm_irq)
    );

    // ops: 0 write status, 1 write enable, 2 wake(arg=why), 3 button,
    // 4 check status, 5 check enable, 6 check {irq,src_pend}, 7 check {rtc_en,tmr_en,arm}
    localparam int NV = 34;
    localparam logic [34:0] VEC [NV] = '{
        {3'd1, 16'h0501, 16'h0}, {3'd5, 16'h0, 16'h0501}, {3'd7, 16'h0, 16'h0007},
        {3'd2, 16'h0000, 16'h0}, {3'd4, 16'h0, 16'h8400}, {3'd6, 16'h0, 16'h000C},
        {3'd0, 16'h0400, 16'h0}, {3'd4, 16'h0, 16'h8000},
        {3'd2, 16'h0003, 16'h0}, {3'd4, 16'h0, 16'h8100}, {3'd6, 16'h0, 16'h000A},
        {3'd0, 16'h8100, 16'h0}, {3'd4, 16'h0, 16'h0000},
        {3'd2, 16'h0001, 16'h0}, {3'd4, 16'h0, 16'h8001}, {3'd6, 16'h0, 16'h0009},
        {3'd7, 16'h0, 16'h0006},
        {3'd0, 16'h8001, 16'h0}, {3'd4, 16'h0, 16'h0000}, {3'd7, 16'h0, 16'h0007},
        {3'd3, 16'h0, 16'h0},    {3'd4, 16'h0, 16'h0100}, {3'd0, 16'h0100, 16'h0},
        {3'd1, 16'h0000, 16'h0}, {3'd7, 16'h0, 16'h0000},
        {3'd3, 16'h0, 16'h0},    {3'd4, 16'h0, 16'h0000},
        {3'd2, 16'h0000, 16'h0}, {3'd4, 16'h0, 16'h8400}, {3'd6, 16'h0, 16'h0000},
        {3'd0, 16'hFFFF, 16'h0}, {3'd2, 16'h0002, 16'h0}, {3'd4, 16'h0, 16'h8100},
        {3'd0, 16'hFFFF, 16'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [3:0] a);
        bus_addr = a;
        return bus_rdata;
    endfunction

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        tmr_tick = 1'b1;
        repeat (n) @(negedge clk);
        tmr_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #600000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 status after reset", 4'd0, 32'h0);
        rd_chk("R1 enable after reset", 4'd2, 32'h0);
        rd_chk("R1 count after reset", 4'd8, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [2:0] op = VEC[i][34:32];
            logic [15:0] arg = VEC[i][31:16];
            logic [15:0] ex = VEC[i][15:0];
            case (op)
                3'd0: wr(4'd0, arg);
                3'd1: wr(4'd2, arg);
                3'd2: begin wake_req = 1'b1; wake_why = arg[1:0]; @(negedge clk); wake_req = 1'b0; end
                3'd3: begin pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0; end
                3'd4: rd_chk("status R3 R5 R6", 4'd0, {16'h0, ex});
                3'd5: rd_chk("enable R7", 4'd2, {16'h0, ex});
                3'd6: begin #1; chk("pending R9", {28'h0, pm_irq, src_pend}, {16'h0, ex}); end
                default: begin #1; chk("wake outputs R7 R8", {29'h0, rtc_wake_en, tmr_wake_en, tmr_wake_arm}, {16'h0, ex}); end
            endcase
        end

        // R2 counting, truncation, ignored writes; R4 disarmed after reset
        do_reset();
        ticks(300);
        rd_chk("R2 count low bits", 4'd8, 32'd44);
        wr(4'd8, 16'hFFFF);
        rd_chk("R2 timer write ignored", 4'd8, 32'd44);
        rd_chk("R4 disarmed no timer status", 4'd0, 32'h0);
        rd_chk("R11 unmapped offset", 4'd4, 32'h0);
        void'(rd(4'd0));

        // R4 overflow point placement
        do_reset();
        ticks(10);
        wr(4'd0, 16'h0001);          // arm: point = 32
        ticks(21);                   // count 31
        @(negedge clk);
        rd_chk("R4 one short of point", 4'd0, 32'h0);
        ticks(1);                    // count 32
        @(negedge clk);
        rd_chk("R4 point reached", 4'd0, 32'h1);
        wr(4'd0, 16'h0000);
        rd_chk("R3 zero write keeps bit", 4'd0, 32'h1);
        wr(4'd0, 16'h0001);          // rearm at 32: point = 64
        rd_chk("R4 clear timer status", 4'd0, 32'h0);
        ticks(31);
        @(negedge clk);
        rd_chk("R4 before next point", 4'd0, 32'h0);
        ticks(1);
        @(negedge clk);
        rd_chk("R4 next point", 4'd0, 32'h1);
        ticks(6);                    // count 70
        wr(4'd0, 16'h0001);          // point = 96
        ticks(25);
        @(negedge clk);
        rd_chk("R4 mid-window rearm short", 4'd0, 32'h0);
        ticks(1);
        @(negedge clk);
        rd_chk("R4 mid-window rearm hit", 4'd0, 32'h1);

        // R10 collisions
        do_reset();
        wr(4'd2, 16'h0100);
        wake_req = 1'b1; wake_why = 2'd0;
        wr(4'd0, 16'h8400);
        wake_req = 1'b0;
        rd_chk("R10 wake beats clear", 4'd0, 32'h8400);
        wr(4'd0, 16'hFFFF);
        pwrbtn_evt = 1'b1;
        wr(4'd0, 16'h0100);
        pwrbtn_evt = 1'b0;
        rd_chk("R10 button beats clear", 4'd0, 32'h0100);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule